// File: doc/BRIEF.md
# Two-Law SPI Serial Clock Generator

This block derives the serial clock of a host-mode SPI controller from the bus clock. It also produces single-cycle strobes that tell the neighbouring shift register when to capture input data and when to present the next output bit. Two divide laws are available. The power-of-two law uses the low four bits of the divider setting and gives divisors from 2 to 65536. The linear law uses all eight bits and gives even divisors from 2 to 512.

The clock runs only while the controller is enabled and a frame is active. Otherwise it rests at the level chosen by the polarity setting. The law select, polarity and phase are captured only while the controller is disabled. The divider setting is captured whenever no frame is running, and it applies to the next frame.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `mode_sel`=0 (power-of-two law), each half period of `sclk` lasts 2^N bus cycles, where N = `div_val[3:0]`; bits 7:4 of `div_val` have no effect in this law.
- R2: With `mode_sel`=1 (linear law), each half period lasts N+1 bus cycles, where N = `div_val` (0..255); with N=0, `sclk` toggles on every bus cycle, so it runs at half the bus clock.
- R3: `mode_sel` is captured only while `enable` is low; changing it while `enable` is high leaves the running clock unchanged.
- R4: While `enable` and `frame_active` are not both high, `sclk` equals the captured polarity (0 or 1). If the running condition is first seen at bus edge k, the first toggle happens at edge k+H-1, where H is the half period.
- R5: `cpol_in` and `cpha_in` are captured only while `enable` is low; changes while `enable` is high affect neither the edges, the strobes nor the idle level after the frame.
- R6: `rise_stb` is high for exactly the one cycle in which `sclk` has just gone from 0 to 1, and `fall_stb` is high for exactly the one cycle in which `sclk` has just gone from 1 to 0.
- R7: Each `sclk` edge raises exactly one of `sample_stb` and `shift_stb`. The leading edge is the one that moves away from the idle level. With phase 0, `sample_stb` marks leading edges and `shift_stb` marks trailing edges; with phase 1 the two are swapped.
- R8: `div_val` is captured only while no frame is running; changing it during a frame has no effect until the next frame.
- R9: One cycle after the running condition drops, `sclk` is back at the idle level and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; configuration is captured while low |
| frame_active | input | 1 | High while a frame is being transferred |
| mode_sel | input | 1 | Divide law: 0 power-of-two, 1 linear |
| div_val | input | 8 | Divider setting N |
| cpol_in | input | 1 | Clock polarity (idle level) |
| cpha_in | input | 1 | Clock phase (0: sample on leading edge) |
| sclk | output | 1 | Serial clock |
| rise_stb | output | 1 | Pulse with each rising edge of sclk |
| fall_stb | output | 1 | Pulse with each falling edge of sclk |
| sample_stb | output | 1 | Pulse: capture input data on this edge |
| shift_stb | output | 1 | Pulse: present next output bit on this edge |

## Verification
A wrong count in the half-period counter shows up at the port as an edge that lands early or late. The very first edge of a frame is already off, because the counter is reloaded before every frame and the error does not wait to accumulate. A stale or wrongly captured polarity, phase or law shows up on the first edge of the next frame, as the wrong level, the wrong period or a swapped sample/shift pulse. A polarity fault also shows in the idle level one cycle after the frame stops. A wrong strobe register shows up in the same cycle as the `sclk` change it should accompany, because each strobe is registered together with the clock level.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  typedef struct packed {
    div_law_e law;
    logic     cpol;
    logic     cpha;
  } sclk_cfg_t;

endpackage

// File: rtl/spi_sclk_cfg.sv
module spi_sclk_cfg
  import spi_sclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      law_in,
  input  logic      cpol_in,
  input  logic      cpha_in,
  output sclk_cfg_t cfg
);

  // Protocol settings are frozen while the controller is enabled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '{law: LAW_POW2, cpol: 1'b0, cpha: 1'b0};
    end else if (!enable) begin
      cfg.law  <= div_law_e'(law_in);
      cfg.cpol <= cpol_in;
      cfg.cpha <= cpha_in;
    end
  end

endmodule

// File: rtl/spi_sclk_tick.sv
module spi_sclk_tick
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  div_law_e         law,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  localparam int POW_BITS = 2 ** EXP_W;
  localparam int HALF_W   = (POW_BITS > DIV_W + 1) ? POW_BITS : DIV_W + 1;

  // Half period in bus cycles for a given law and setting.
  function automatic logic [HALF_W-1:0] half_of(input div_law_e l,
                                                 input logic [DIV_W-1:0] n);
    if (l == LAW_POW2) return HALF_W'(1) << n[EXP_W-1:0];
    else               return HALF_W'(n) + HALF_W'(1);
  endfunction

  logic [HALF_W-1:0] half_live;
  logic [HALF_W-1:0] half_q;
  logic [HALF_W-1:0] cnt_q;

  assign half_live = half_of(law, div_val);
  assign tick      = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= HALF_W'(1);
      cnt_q  <= '0;
    end else if (!run) begin
      half_q <= half_live;
      cnt_q  <= half_live - HALF_W'(1);
    end else if (cnt_q == '0) begin
      cnt_q  <= half_q - HALF_W'(1);
    end else begin
      cnt_q  <= cnt_q - HALF_W'(1);
    end
  end

endmodule

// File: rtl/spi_sclk_edge.sv
module spi_sclk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic cpol,
  input  logic cpha,
  output logic sclk,
  output logic rise_stb,
  output logic fall_stb,
  output logic sample_stb,
  output logic shift_stb
);

  logic next_lvl;
  logic leading;

  assign next_lvl = ~sclk;
  assign leading  = next_lvl ^ cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk       <= 1'b0;
      rise_stb   <= 1'b0;
      fall_stb   <= 1'b0;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
    end else begin
      rise_stb   <= 1'b0;
      fall_stb   <= 1'b0;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
      if (!run) begin
        sclk <= cpol;
      end else if (tick) begin
        sclk       <= next_lvl;
        rise_stb   <= next_lvl;
        fall_stb   <= ~next_lvl;
        sample_stb <= leading ^ cpha;
        shift_stb  <= ~(leading ^ cpha);
      end
    end
  end

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             frame_active,
  input  logic             mode_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cpol_in,
  input  logic             cpha_in,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             sample_stb,
  output logic             shift_stb
);

  sclk_cfg_t cfg_q;
  logic      run;
  logic      tick;
  logic      cfg_law;
  logic      cfg_cpol;
  logic      cfg_cpha;

  assign run      = enable && frame_active;
  assign cfg_law  = cfg_q.law;
  assign cfg_cpol = cfg_q.cpol;
  assign cfg_cpha = cfg_q.cpha;

  spi_sclk_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .law_in  (mode_sel),
    .cpol_in (cpol_in),
    .cpha_in (cpha_in),
    .cfg     (cfg_q)
  );

  spi_sclk_tick #(.DIV_W(DIV_W), .EXP_W(EXP_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .law     (cfg_q.law),
    .div_val (div_val),
    .tick    (tick)
  );

  spi_sclk_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tick       (tick),
    .cpol       (cfg_cpol),
    .cpha       (cfg_cpha),
    .sclk       (sclk),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb)
  );

endmodule

// File: rtl/spi_sclk_chk.sv
module spi_sclk_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic run,
  input logic tick,
  input logic cfg_law,
  input logic cfg_cpol,
  input logic cfg_cpha,
  input logic sclk,
  input logic rise_stb,
  input logic fall_stb,
  input logic sample_stb,
  input logic shift_stb
);

  // R3 R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable({cfg_law, cfg_cpol, cfg_cpha}));

  // R6
  rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> (sclk && !$past(sclk)));

  // R6
  fall_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> (!sclk && $past(sclk)));

  // R7
  one_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb || fall_stb) |-> ($countones({sample_stb, shift_stb}) == 1));

  // R7
  no_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb || fall_stb) |-> (!sample_stb && !shift_stb));

  // R1 R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> ($stable(sclk) && !rise_stb && !fall_stb));

  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == $past(cfg_cpol) && !rise_stb && !fall_stb));

endmodule

bind spi_sclk_gen spi_sclk_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .run        (run),
  .tick       (tick),
  .cfg_law    (cfg_law),
  .cfg_cpol   (cfg_cpol),
  .cfg_cpha   (cfg_cpha),
  .sclk       (sclk),
  .rise_stb   (rise_stb),
  .fall_stb   (fall_stb),
  .sample_stb (sample_stb),
  .shift_stb  (shift_stb)
);

// File: tb/sim_spi_sclk_gen.sv
`timescale 1ns/1ps
module sim_spi_sclk_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       frame_active = 1'b0;
  logic       mode_sel = 1'b0;
  logic [7:0] div_val = 8'd0;
  logic       cpol_in = 1'b0;
  logic       cpha_in = 1'b0;
  logic       sclk, rise_stb, fall_stb, sample_stb, shift_stb;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int    at;
    bit    lvl;
    bit    smp;
    string tag;
  } edge_t;
  edge_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_sclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .frame_active(frame_active),
    .mode_sel(mode_sel), .div_val(div_val), .cpol_in(cpol_in), .cpha_in(cpha_in),
    .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: every observed edge is compared with the next expected one.
  always @(negedge clk) begin
    if (rst_n && (rise_stb || fall_stb)) begin
      if (q.size() == 0) begin
        chk(0, "R4 unexpected edge at cycle", cyc, -1);
      end else begin
        edge_t e;
        e = q.pop_front();
        chk(cyc == e.at, {e.tag, " edge cycle"}, cyc, e.at);
        chk(sclk == e.lvl && rise_stb == e.lvl && fall_stb == !e.lvl,
            "R6 level/strobe", {sclk, rise_stb, fall_stb}, {e.lvl, e.lvl, !e.lvl});
        chk(sample_stb == e.smp && shift_stb == !e.smp,
            "R7 sample/shift", {sample_stb, shift_stb}, {e.smp, !e.smp});
      end
    end
  end

  // Driver: configure, run n edges, stop, check idle.
  task automatic run_frame(input bit law, input logic [7:0] n, input bit pol,
                           input bit pha, input int edges, input bit perturb,
                           input string tag);
    int h;
    int start;
    @(negedge clk);
    enable = 0; frame_active = 0;
    mode_sel = law; div_val = n; cpol_in = pol; cpha_in = pha;
    repeat (3) @(negedge clk);
    chk(sclk == pol, "R4 idle level before frame", sclk, pol);
    enable = 1;
    @(negedge clk);
    h = law ? (int'(n) + 1) : (1 << (n & 8'h0f));
    start = cyc;
    for (int k = 1; k <= edges; k++) begin
      edge_t e;
      e.at  = start + k * h;
      e.lvl = (k % 2 == 1) ? !pol : pol;
      e.smp = (k % 2 == 1) ? !pha : pha;
      e.tag = tag;
      q.push_back(e);
    end
    frame_active = 1;
    if (perturb) begin
      @(negedge clk);
      // R3 R5 R8: these changes must not alter the running frame
      mode_sel = !law; cpol_in = !pol; cpha_in = !pha; div_val = n ^ 8'h05;
    end
    while (cyc < start + edges * h) @(negedge clk);
    frame_active = 0;
    repeat (2) @(negedge clk);
    chk(sclk == pol, "R9 idle after frame", sclk, pol);
    chk(q.size() == 0, "R4 missing edges", q.size(), 0);
    chk(!rise_stb && !fall_stb && !sample_stb && !shift_stb,
        "R9 no strobe when stopped", {rise_stb, fall_stb, sample_stb, shift_stb}, 0);
    q.delete();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk == 0 && !rise_stb && !fall_stb && !sample_stb && !shift_stb,
        "R4 reset state", {sclk, rise_stb, fall_stb, sample_stb, shift_stb}, 0);
    rst_n = 1;
    @(negedge clk);
    run_frame(1, 8'd0,   0, 0, 6, 0, "R2 linear N=0");
    run_frame(1, 8'd3,   1, 1, 5, 0, "R2 linear N=3");
    run_frame(1, 8'd255, 0, 1, 2, 0, "R2 linear N=255");
    run_frame(0, 8'd0,   1, 0, 4, 0, "R1 pow2 N=0");
    run_frame(0, 8'd2,   0, 1, 4, 0, "R1 pow2 N=2");
    run_frame(0, 8'h13,  1, 1, 3, 0, "R1 pow2 upper bits ignored");
    run_frame(0, 8'd10,  0, 0, 2, 0, "R1 pow2 N=10");
    run_frame(1, 8'd4,   0, 0, 6, 1, "R5 R3 R8 linear changes ignored");
    run_frame(0, 8'd1,   1, 1, 6, 1, "R5 R3 R8 pow2 changes ignored");
    done = 1;
    summary();
  end

endmodule